// File: doc/BRIEF.md
# Carry-Free Redundant-Digit Adder

This block adds two numbers held as D digits of a redundant radix-2^R format. Each digit is R+2 bits wide. The low R bits are the principal part, and the two bits above them are a redundant spill field. Digit i has weight 2^(i*R). Each result digit is built from only its own principal bits and the redundant field of the digit just below it. No carry travels from one digit to the next, so the adder depth stays the same for any D. This makes it suitable as the accumulate stage of wide multiply-reduce datapaths.

Two converters are provided next to the adder. The first widens a plain binary value into redundant form by attaching a zero redundant field to every digit. The second turns a redundant value whose redundant fields are all zero back into plain binary by removing those fields. The block is purely combinational. The caller must keep operands and sums below 2^(D*R) and keep the top digit's redundant field clear. Results that overflow are not defined.

Top module: `rdx_cf_adder`

## Requirements
- R1: Digit i of every redundant vector occupies bits [i*(R+2)+R+1 : i*(R+2)]. The low R bits of the digit are the principal part, the upper 2 bits are the redundant field, and the digit weight is 2^(i*R).
- R2: Result digit 0 equals the sum of the principal parts of operand digit 0 of x and y. Its most significant bit is therefore always 0.
- R3: For 1 <= i < D, result digit i equals x principal i + y principal i + x redundant field (i-1) + y redundant field (i-1).
- R4: No result digit is truncated. With R >= 2 each digit sum fits in R+2 bits, including when every principal part is all ones and every redundant field is 3.
- R5: The redundant field of the top operand digit of x and of y has no effect on sum_o.
- R6: red_o equals bin_i with every R-bit group i placed in digit i and the redundant field of every digit set to 00.
- R7: bin_o equals the principal parts of red_in_i, with digit i placed at bits [i*R+R-1 : i*R]. The redundant fields are dropped whatever their value.
- R8: For operands whose values and sum stay below 2^(D*R) and whose top redundant fields are zero, the numeric value of sum_o equals value(x) + value(y).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_i | input | D*(R+2) | First redundant operand |
| y_i | input | D*(R+2) | Second redundant operand |
| sum_o | output | D*(R+2) | Redundant sum, no inter-digit carry |
| bin_i | input | D*R | Plain binary value to widen |
| red_o | output | D*(R+2) | bin_i in redundant form |
| red_in_i | input | D*(R+2) | Redundant value with clear redundant fields |
| bin_o | output | D*R | red_in_i in plain binary form |

## Verification
The bench builds the block with its defaults, R=16 and D=4, so that the 64-bit integer value of each redundant vector fits comfortably in a 128-bit reference accumulator. At this size the corner cases are within reach: all-ones principal parts with full redundant fields, which give the largest digit sum of 0x20004, and a top redundant field that must be ignored. Random operands with random redundant fields in every lower digit exercise the position-sum rule across all three digit boundaries. These results are compared by value against an integer reference sum.

// File: rtl/rdx_pkg.sv
package rdx_pkg;
  localparam int RED_W = 2;

  function automatic int digit_w(input int r);
    return r + RED_W;
  endfunction
endpackage

// File: rtl/rdx_digit_add.sv
module rdx_digit_add
  import rdx_pkg::*;
#(
  parameter int R = 16
) (
  input  logic [R-1:0]            xp_i,
  input  logic [R-1:0]            yp_i,
  input  logic [RED_W-1:0]        xr_i,
  input  logic [RED_W-1:0]        yr_i,
  output logic [digit_w(R)-1:0]   sum_o
);
  localparam int DW = digit_w(R);
  localparam int SW = DW + 1;

  logic [SW-1:0] wide;

  assign wide  = SW'(xp_i) + SW'(yp_i) + SW'(xr_i) + SW'(yr_i);
  assign sum_o = wide[DW-1:0];

  always_comb begin
    assert_digit_fits_R4: assert (wide[SW-1] == 1'b0)
      else $error("digit sum exceeds R+2 bits");
  end
endmodule

// File: rtl/rdx_from_binary.sv
module rdx_from_binary
  import rdx_pkg::*;
#(
  parameter int R = 16,
  parameter int D = 4
) (
  input  logic [D*R-1:0]          bin_i,
  output logic [D*digit_w(R)-1:0] red_o
);
  localparam int DW = digit_w(R);

  for (genvar i = 0; i < D; i++) begin : g_dig
    assign red_o[i*DW +: DW] = {{RED_W{1'b0}}, bin_i[i*R +: R]};
  end
endmodule

// File: rtl/rdx_to_binary.sv
module rdx_to_binary
  import rdx_pkg::*;
#(
  parameter int R = 16,
  parameter int D = 4
) (
  input  logic [D*digit_w(R)-1:0] red_i,
  output logic [D*R-1:0]          bin_o
);
  localparam int DW = digit_w(R);

  for (genvar i = 0; i < D; i++) begin : g_dig
    logic [RED_W-1:0] unused_red;
    assign unused_red = red_i[i*DW+R +: RED_W];
    assign bin_o[i*R +: R] = red_i[i*DW +: R];
  end
endmodule

// File: rtl/rdx_cf_adder.sv
module rdx_cf_adder
  import rdx_pkg::*;
#(
  parameter int R = 16,
  parameter int D = 4
) (
  input  logic [D*(R+2)-1:0] x_i,
  input  logic [D*(R+2)-1:0] y_i,
  output logic [D*(R+2)-1:0] sum_o,
  input  logic [D*R-1:0]     bin_i,
  output logic [D*(R+2)-1:0] red_o,
  input  logic [D*(R+2)-1:0] red_in_i,
  output logic [D*R-1:0]     bin_o
);
  localparam int DW = digit_w(R);
  localparam int W  = D * DW;

  // top redundant fields are outside the valid range and are dropped
  logic [2*RED_W-1:0] unused_top;
  assign unused_top = {x_i[W-1 -: RED_W], y_i[W-1 -: RED_W]};

  for (genvar i = 0; i < D; i++) begin : g_dig
    logic [RED_W-1:0] xl, yl;
    if (i == 0) begin : g_lo
      assign xl = '0;
      assign yl = '0;
    end else begin : g_hi
      assign xl = x_i[(i-1)*DW+R +: RED_W];
      assign yl = y_i[(i-1)*DW+R +: RED_W];
    end

    rdx_digit_add #(.R(R)) u_add (
      .xp_i  (x_i[i*DW +: R]),
      .yp_i  (y_i[i*DW +: R]),
      .xr_i  (xl),
      .yr_i  (yl),
      .sum_o (sum_o[i*DW +: DW])
    );
  end

  rdx_from_binary #(.R(R), .D(D)) u_from_bin (
    .bin_i (bin_i),
    .red_o (red_o)
  );

  rdx_to_binary #(.R(R), .D(D)) u_to_bin (
    .red_i (red_in_i),
    .bin_o (bin_o)
  );

  always_comb begin
    assert_low_digit_R2: assert (sum_o[DW-1] == 1'b0)
      else $error("digit 0 sum uses its top bit");
    for (int i = 0; i < D; i++) begin
      assert_red_clear_R6: assert (red_o[i*DW+R +: RED_W] == '0)
        else $error("widened digit %0d has nonzero redundant field", i);
      assert_prin_kept_R7: assert (bin_o[i*R +: R] == red_in_i[i*DW +: R])
        else $error("binary group %0d differs from principal part", i);
    end
  end
endmodule

// File: tb/rdx_cf_adder_tb_top.sv
`timescale 1ns/1ps
module rdx_cf_adder_tb_top;
  localparam int R  = 16;
  localparam int D  = 4;
  localparam int DW = R + 2;
  localparam int W  = D * DW;
  localparam int BW = D * R;

  typedef struct {
    int           kind;   // 0 exact sum, 1 sum value, 2 red_o, 3 bin_o
    logic [W-1:0] exp;
    logic [127:0] ev;
    string        req;
  } item_t;

  logic clk;
  logic [W-1:0]  x_i, y_i, sum_o, red_o, red_in_i;
  logic [BW-1:0] bin_i, bin_o;

  item_t sb[$];
  int checks = 0;
  int failures = 0;

  rdx_cf_adder #(.R(R), .D(D)) dut_i (
    .x_i(x_i), .y_i(y_i), .sum_o(sum_o),
    .bin_i(bin_i), .red_o(red_o),
    .red_in_i(red_in_i), .bin_o(bin_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [W-1:0] put(logic [W-1:0] v, int i, logic [DW-1:0] dg);
    logic [W-1:0] r = v;
    r[i*DW +: DW] = dg;
    return r;
  endfunction

  function automatic logic [127:0] val(logic [W-1:0] v);
    logic [127:0] acc = '0;
    for (int i = 0; i < D; i++) acc += 128'(v[i*DW +: DW]) << (i*R);
    return acc;
  endfunction

  task automatic push(int kind, logic [W-1:0] exp, logic [127:0] ev, string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.ev = ev; it.req = req;
    sb.push_back(it);
  endtask

  task automatic drive_add(logic [W-1:0] x, logic [W-1:0] y, int kind,
                           logic [W-1:0] exp, string req);
    @(negedge clk);
    x_i = x; y_i = y;
    push(kind, exp, val(x) + val(y), req);
  endtask

  task automatic drive_widen(logic [BW-1:0] b);
    logic [W-1:0] e = '0;
    for (int i = 0; i < D; i++) e = put(e, i, {2'b00, b[i*R +: R]});
    @(negedge clk);
    bin_i = b;
    push(2, e, '0, "R6");
  endtask

  task automatic drive_narrow(logic [W-1:0] v);
    logic [W-1:0] e = '0;
    for (int i = 0; i < D; i++) e[i*R +: R] = v[i*DW +: R];
    @(negedge clk);
    red_in_i = v;
    push(3, e, '0, "R7");
  endtask

  // monitor: compare after each rising edge, away from input changes
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        case (it.kind)
          0: if (sum_o !== it.exp) begin
               failures++;
               $display("FAIL %s sum_o actual=%h expected=%h", it.req, sum_o, it.exp);
             end
          1: if (val(sum_o) !== it.ev) begin
               failures++;
               $display("FAIL %s value actual=%h expected=%h", it.req, val(sum_o), it.ev);
             end
          2: if (red_o !== it.exp) begin
               failures++;
               $display("FAIL %s red_o actual=%h expected=%h", it.req, red_o, it.exp);
             end
          default: if (bin_o !== it.exp[BW-1:0]) begin
               failures++;
               $display("FAIL %s bin_o actual=%h expected=%h", it.req, bin_o, it.exp[BW-1:0]);
             end
        endcase
      end
    end
  end

  task automatic run_all();
    logic [W-1:0] x, y, e;
    // zero operands
    drive_add('0, '0, 0, '0, "R2");

    // R2 R3: full digit 0 in both operands spills 6 into digit 1
    x = put('0, 0, {2'b11, 16'hFFFF});
    y = x;
    e = put('0, 0, 18'h1FFFE);
    e = put(e, 1, 18'h00006);
    drive_add(x, y, 0, e, "R2 R3");

    // R1 R3: redundant 2 and 1 in digit 1, principal 5 and 7 in digit 2
    x = put('0, 1, {2'b10, 16'h0000});
    x = put(x, 2, 18'h00005);
    y = put('0, 1, {2'b01, 16'h0000});
    y = put(y, 2, 18'h00007);
    e = put('0, 2, 18'h0000F);
    drive_add(x, y, 0, e, "R1 R3");

    // R4: every field at maximum, top redundant fields set
    x = '0;
    for (int i = 0; i < D; i++) x = put(x, i, {2'b11, 16'hFFFF});
    y = x;
    e = put('0, 0, 18'h1FFFE);
    for (int i = 1; i < D; i++) e = put(e, i, 18'h20004);
    drive_add(x, y, 0, e, "R4");

    // R5: top redundant fields cleared, result unchanged
    x[W-1 -: 2] = 2'b00;
    drive_add(x, y, 0, e, "R5");
    y[W-1 -: 2] = 2'b10;
    x[W-1 -: 2] = 2'b01;
    drive_add(x, y, 0, e, "R5");

    // R8: random operands with random lower redundant fields
    for (int n = 0; n < 40; n++) begin
      x = '0; y = '0;
      for (int i = 0; i < D-1; i++) begin
        x = put(x, i, DW'($urandom));
        y = put(y, i, DW'($urandom));
      end
      x = put(x, D-1, {2'b00, R'($urandom) >> 2});
      y = put(y, D-1, {2'b00, R'($urandom) >> 2});
      drive_add(x, y, 1, '0, "R8");
    end

    // R6 widening
    drive_widen('0);
    drive_widen('1);
    for (int n = 0; n < 4; n++) drive_widen({$urandom, $urandom});

    // R7 narrowing: clear redundant fields, then arbitrary ones dropped
    x = '0;
    for (int i = 0; i < D; i++) x = put(x, i, {2'b00, R'($urandom)});
    drive_narrow(x);
    drive_narrow('1);
    for (int n = 0; n < 3; n++) drive_narrow({$urandom, $urandom, $urandom});

    @(posedge clk);
    @(posedge clk);
    #2;
  endtask

  initial begin
    x_i = '0; y_i = '0; bin_i = '0; red_in_i = '0;
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL R8 watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule